// File: doc/BRIEF.md
# Battery-Domain Week Timer Core

This block keeps long-interval time on a slow 32.768 kHz timebase. The chip supplies that timebase as a one-cycle enable, `tick_32k`, on a faster clock. A 15-bit prescaler turns the enable into a one-second tick and a programmable sub-second tick. The one-second tick drives a 32-bit seconds counter, which has an alarm compare. A 16-bit sub-week down-counter takes its step from one of several selectable sources and can reload itself after it expires.

Software configures the block through a simple write-only register port with a 3-bit address and 32 bits of data. The block reports three single-cycle event pulses: sub-second, seconds alarm and sub-week expiry. Each pulse also sets a sticky status bit, and software clears a status bit by writing 1 to it. The seconds count, the sub-week count and two stored wake-enable flags are brought out as plain outputs.

Top module: `wk_timer_core`

## Requirements
- R1: While the run flag is set, the prescaler advances on each edge where `tick_32k` is high. The seconds counter increments by one on the enabled tick where the prescaler wraps from 32767 to 0, so once every 32768 enabled ticks.
- R2: Sub-second rate codes 1 to 8 (register address 1, bits 3:0) pulse `subsec_evt` once every 2^(15-code) enabled ticks. The pulse comes on the edge where the enabled-tick total becomes a multiple of that divisor.
- R3: Rate codes 9 to 14 pulse `subsec_evt` once every 2^(14-code) enabled ticks. This gives 1024 Hz up to 32768 Hz; no code gives 512 Hz.
- R4: Rate code 0 and rate code 15 produce no sub-second pulses.
- R5: Sub-week source codes (register address 2, bits 2:0) select what steps the sub-week counter:
  - 1 steps it on the sub-second tick;
  - 2 steps it on the one-second tick;
  - 3, 4, 5 and 6 step it when bit 3, 5, 7 or 9 of the seconds counter toggles;
  - 0 and 7 never step it.
- R6: Each step decrements a non-zero sub-week count. The step that reaches zero pulses `subwk_evt` on the same edge. If reload is enabled (register address 0, bit 3), that step loads the reload value instead of zero.
- R7: With reload disabled, the sub-week counter stays at zero after it expires.
- R8: A seconds increment that makes the count equal the alarm value (register address 4) pulses `alarm_evt` on the same edge.
- R9: With the run flag (address 0, bit 0) clear, or with `tick_32k` low, the prescaler and all counters hold and no event pulses occur.
- R10: Writes load on the next clock edge:
  - a write to address 3 loads the seconds count;
  - a write to address 5 loads both the reload value and the sub-week count.
- R11: Event outputs are single-cycle pulses. Each pulse sets a status bit on the following edge: bit 0 for sub-second, bit 1 for alarm, bit 2 for sub-week. A write to address 6 clears the status bits written as 1, and a new event wins over a clear in the same cycle.
- R12: Control bits 1 and 2 (address 0) are stored, appear on `wake_flags[0]` and `wake_flags[1]`, and do not affect counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| subsec_evt | output | 1 | Sub-second event pulse |
| alarm_evt | output | 1 | Seconds alarm event pulse |
| subwk_evt | output | 1 | Sub-week expiry event pulse |
| status | output | 3 | Sticky event status {sub-week, alarm, sub-second} |
| sec_count | output | 32 | Current seconds count |
| subwk_count | output | 16 | Current sub-week count |
| wake_flags | output | 2 | Stored wake-enable control bits |

## Verification
The bench goes after the rate-code split around the missing 512 Hz setting, by running codes 8 and 9 and expecting divisors of 128 and 32. A design that kept a plain power-of-two ladder would pulse at half or double the expected spacing. It drives the invalid codes 15 and 7 and expects complete silence; a design that decoded them as a real rate or source would step or pulse. It crosses a seconds boundary from 7 to 8 with the bit-3 tap selected and the alarm set to 8. A wrong tap index, or an alarm compared against the old count, would put the events on the wrong edge or drop them. It also checks reload against stop-at-zero, freezing with the run flag clear or `tick_32k` low, and a partial write-1-clear of the status. Each of these exposes a design that keeps counting, wraps past zero or clears the wrong bits.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    localparam int RATE_W   = 4;
    localparam int SRC_W    = 3;
    localparam int SRC_CNT  = 1 << SRC_W;
    localparam int ADDR_W   = 3;
    localparam int STAT_W   = 3;
    localparam int TAP_N    = 4;
    localparam int TAP_BASE = 3;
    localparam int TAP_STEP = 2;

    localparam logic [RATE_W-1:0] RATE_LOW_LAST  = 4'd8;
    localparam logic [RATE_W-1:0] RATE_HIGH_LAST = 4'd14;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_RATE   = 3'd1,
        REG_SRC    = 3'd2,
        REG_SECS   = 3'd3,
        REG_ALARM  = 3'd4,
        REG_RELOAD = 3'd5,
        REG_STAT   = 3'd6,
        REG_SPARE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic reload_en;
        logic syspwr_en;
        logic wake_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/wkt_prescale.sv
module wkt_prescale
    import wkt_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              sec_tick,
    output logic              sub_tick,
    output logic              sub_evt
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             evt;
    } pre_state_t;

    pre_state_t s_q, s_d;
    logic [PRE_W-1:0] mask;
    logic             rate_ok;
    logic             adv;

    // Divisor mask: the low-rate codes halve per step from 2 Hz, the high
    // codes resume one octave above the skipped setting.
    always_comb begin
        rate_ok = 1'b1;
        mask    = '0;
        if (rate >= 4'd1 && rate <= RATE_LOW_LAST) begin
            mask = PRE_W'((32'd1 << (PRE_W - int'(rate))) - 32'd1);
        end else if (rate > RATE_LOW_LAST && rate <= RATE_HIGH_LAST) begin
            mask = PRE_W'((32'd1 << (PRE_W - 1 - int'(rate))) - 32'd1);
        end else begin
            rate_ok = 1'b0;
        end
    end

    assign adv      = en & tick;
    assign sec_tick = adv & (&s_q.pre);
    assign sub_tick = adv & rate_ok & ((s_q.pre & mask) == mask);
    assign sub_evt  = s_q.evt;

    always_comb begin
        s_d     = s_q;
        s_d.evt = sub_tick;
        if (adv) begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wkt_seconds.sv
module wkt_seconds
    import wkt_pkg::*;
#(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             ld_cnt,
    input  logic             ld_alarm,
    input  logic [SEC_W-1:0] wdata,
    output logic [SEC_W-1:0] count,
    output logic [SEC_W-1:0] alarm,
    output logic             alarm_evt,
    output logic [TAP_N-1:0] tap_tick
);
    typedef struct packed {
        logic [SEC_W-1:0] cnt;
        logic [SEC_W-1:0] alm;
        logic             evt;
    } sec_state_t;

    sec_state_t s_q, s_d;
    logic [SEC_W-1:0] cnt_inc;

    assign cnt_inc = s_q.cnt + SEC_W'(1);

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        if (ld_alarm) begin
            s_d.alm = wdata;
        end
        if (ld_cnt) begin
            s_d.cnt = wdata;
        end else if (sec_tick) begin
            s_d.cnt = cnt_inc;
            s_d.evt = (cnt_inc == s_d.alm);
        end
    end

    // A seconds bit toggles on the increment that carries through every bit below it.
    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        localparam int TB = TAP_BASE + TAP_STEP * i;
        assign tap_tick[i] = sec_tick & (&s_q.cnt[TB-1:0]);
    end

    assign count     = s_q.cnt;
    assign alarm     = s_q.alm;
    assign alarm_evt = s_q.evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wkt_subweek.sv
module wkt_subweek
    import wkt_pkg::*;
#(
    parameter int SW_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_CNT-1:0] tick_vec,
    input  logic [SRC_W-1:0]   src,
    input  logic               reload_en,
    input  logic               ld,
    input  logic [SW_W-1:0]    wdata,
    output logic [SW_W-1:0]    count,
    output logic [SW_W-1:0]    reload,
    output logic               evt
);
    typedef struct packed {
        logic [SW_W-1:0] cnt;
        logic [SW_W-1:0] rld;
        logic            evt;
    } sw_state_t;

    sw_state_t s_q, s_d;
    logic      step;

    assign step = tick_vec[src];

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        if (ld) begin
            s_d.rld = wdata;
            s_d.cnt = wdata;
        end else if (step && s_q.cnt != '0) begin
            if (s_q.cnt == SW_W'(1)) begin
                s_d.evt = 1'b1;
                s_d.cnt = reload_en ? s_q.rld : '0;
            end else begin
                s_d.cnt = s_q.cnt - SW_W'(1);
            end
        end
    end

    assign count  = s_q.cnt;
    assign reload = s_q.rld;
    assign evt    = s_q.evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wk_timer_core.sv
module wk_timer_core
    import wkt_pkg::*;
#(
    parameter int PRE_W  = 15,
    parameter int SEC_W  = 32,
    parameter int SW_W   = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              subsec_evt,
    output logic              alarm_evt,
    output logic              subwk_evt,
    output logic [STAT_W-1:0] status,
    output logic [SEC_W-1:0]  sec_count,
    output logic [SW_W-1:0]   subwk_count,
    output logic [1:0]        wake_flags
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [RATE_W-1:0] rate;
        logic [SRC_W-1:0]  src;
        logic [STAT_W-1:0] stat;
    } cfg_state_t;

    cfg_state_t r_q, r_d;

    logic               sec_tick, sub_tick;
    logic [TAP_N-1:0]   tap_tick;
    logic [SRC_CNT-1:0] tick_vec;
    logic               ld_secs, ld_alarm, ld_reload;
    logic [SEC_W-1:0]   alarm_val;
    logic [SW_W-1:0]    reload_val;
    logic               run_en, reload_en;

    assign run_en    = r_q.ctrl.run;
    assign reload_en = r_q.ctrl.reload_en;
    assign ld_secs   = wr_en && (wr_addr == REG_SECS);
    assign ld_alarm  = wr_en && (wr_addr == REG_ALARM);
    assign ld_reload = wr_en && (wr_addr == REG_RELOAD);

    always_comb begin
        r_d      = r_q;
        r_d.stat = r_q.stat;
        if (wr_en) begin
            case (wr_addr)
                REG_CTRL: r_d.ctrl = ctrl_t'(wr_data[3:0]);
                REG_RATE: r_d.rate = wr_data[RATE_W-1:0];
                REG_SRC:  r_d.src  = wr_data[SRC_W-1:0];
                REG_STAT: r_d.stat = r_q.stat & ~wr_data[STAT_W-1:0];
                default:  ;
            endcase
        end
        r_d.stat = r_d.stat | {subwk_evt, alarm_evt, subsec_evt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    wkt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .tick     (tick_32k),
        .rate     (r_q.rate),
        .sec_tick (sec_tick),
        .sub_tick (sub_tick),
        .sub_evt  (subsec_evt)
    );

    wkt_seconds #(.SEC_W(SEC_W)) u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .ld_cnt    (ld_secs),
        .ld_alarm  (ld_alarm),
        .wdata     (wr_data[SEC_W-1:0]),
        .count     (sec_count),
        .alarm     (alarm_val),
        .alarm_evt (alarm_evt),
        .tap_tick  (tap_tick)
    );

    // Source code indexes this vector: 0 off, 1 sub-second, 2 seconds, 3..6 taps, 7 off.
    assign tick_vec = {1'b0, tap_tick, sec_tick, sub_tick, 1'b0};

    wkt_subweek #(.SW_W(SW_W)) u_swk (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_vec  (tick_vec),
        .src       (r_q.src),
        .reload_en (reload_en),
        .ld        (ld_reload),
        .wdata     (wr_data[SW_W-1:0]),
        .count     (subwk_count),
        .reload    (reload_val),
        .evt       (subwk_evt)
    );

    assign status     = r_q.stat;
    assign wake_flags = {r_q.ctrl.syspwr_en, r_q.ctrl.wake_en};
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker
    import wkt_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SW_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              run_en,
    input logic              reload_en,
    input logic [SEC_W-1:0]  sec_count,
    input logic [SEC_W-1:0]  alarm_val,
    input logic [SW_W-1:0]   subwk_count,
    input logic [SW_W-1:0]   reload_val,
    input logic              alarm_evt,
    input logic              subwk_evt,
    input logic [STAT_W-1:0] status
);
    // R1
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (sec_count == $past(sec_count) || sec_count == $past(sec_count) + SEC_W'(1)));

    // R8
    alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> (sec_count == alarm_val));

    // R11
    alarm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt);

    // R6
    swk_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        subwk_evt |-> (subwk_count == '0 || subwk_count == reload_val));

    // R7
    swk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (subwk_count == '0 && !reload_en && !wr_en) |=> (subwk_count == '0));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> ($stable(sec_count) && $stable(subwk_count)));

    // R11
    sticky_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> status[1]);

    // R11
    sticky_swk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        subwk_evt |=> status[2]);
endmodule

bind wk_timer_core wkt_checker #(.SEC_W(SEC_W), .SW_W(SW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .run_en      (run_en),
    .reload_en   (reload_en),
    .sec_count   (sec_count),
    .alarm_val   (alarm_val),
    .subwk_count (subwk_count),
    .reload_val  (reload_val),
    .alarm_evt   (alarm_evt),
    .subwk_evt   (subwk_evt),
    .status      (status)
);

// File: tb/tb_wk_timer_core.sv
module tb_wk_timer_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_32k = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        subsec_evt, alarm_evt, subwk_evt;
    logic [2:0]  status;
    logic [31:0] sec_count;
    logic [15:0] subwk_count;
    logic [1:0]  wake_flags;

    always #10 clk = ~clk;

    wk_timer_core dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .subsec_evt(subsec_evt), .alarm_evt(alarm_evt), .subwk_evt(subwk_evt),
        .status(status), .sec_count(sec_count), .subwk_count(subwk_count),
        .wake_flags(wake_flags)
    );

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int pcount = 0;
    int e_cyc = 0;
    int q_sub[$];
    int q_alm[$];
    int q_swk[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pop_cmp(string req, ref int q[$]);
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL %s actual event at %0d expected none", req, cyc);
        end else begin
            int e;
            e = q.pop_front();
            if (e != cyc) begin
                errors++;
                $display("FAIL %s actual event at %0d expected %0d", req, cyc, e);
            end
        end
    endtask

    // Monitor: pops expected event cycles as pulses appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (subsec_evt) pop_cmp("R2 subsec", q_sub);
            if (alarm_evt)  pop_cmp("R8 alarm", q_alm);
            if (subwk_evt)  pop_cmp("R6 subweek", q_swk);
        end
    end

    task automatic wr(int a, longint d);
        wr_en   = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[31:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_sub(int e, int len, int div);
        for (int j = 1; j <= len; j++) begin
            if ((pcount + j) % div == 0) q_sub.push_back(e + j);
        end
    endtask

    task automatic drain();
        check("R2 missing subsec", longint'(q_sub.size()), 0);
        check("R8 missing alarm", longint'(q_alm.size()), 0);
        check("R6 missing subweek", longint'(q_swk.size()), 0);
        q_sub.delete();
        q_alm.delete();
        q_swk.delete();
    endtask

    task automatic go(int ctrl);
        wr(0, longint'(ctrl | 1));
        e_cyc = cyc;
    endtask

    task automatic stop(int ctrl, int len);
        idle(len - 1);
        wr(0, longint'(ctrl & ~1));
        idle(1);
        drain();
        if (tick_32k) pcount += len;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL R9 watchdog actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int lt;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R11 reset status", longint'(status), 0);
        check("R1 reset seconds", longint'(sec_count), 0);
        check("R6 reset subweek", longint'(subwk_count), 0);
        check("R12 reset flags", longint'(wake_flags), 0);
        tick_32k = 1'b1;

        // Fastest rate steps sub-week; reload 3 with auto-reload.
        wr(1, 14); wr(2, 1); wr(5, 3);
        check("R10 reload load", longint'(subwk_count), 3);
        go(8);
        push_sub(e_cyc, 11, 1);
        q_swk.push_back(e_cyc + 3); q_swk.push_back(e_cyc + 6); q_swk.push_back(e_cyc + 9);
        stop(8, 11);
        check("R6 count after reloads", longint'(subwk_count), 1);
        check("R11 sticky status", longint'(status), 5);
        wr(6, 1);
        check("R11 partial clear", longint'(status), 4);
        wr(6, 4);
        check("R11 full clear", longint'(status), 0);

        // No reload: stop at zero.
        wr(0, 0); wr(5, 2);
        go(0);
        push_sub(e_cyc, 7, 1);
        q_swk.push_back(e_cyc + 2);
        stop(0, 7);
        check("R7 hold at zero", longint'(subwk_count), 0);

        // R3: code 9 is 1024 Hz (divisor 32), not 512 Hz.
        wr(1, 9); wr(2, 0);
        go(0);
        push_sub(e_cyc, 101, 32);
        stop(0, 101);

        // R2: code 8 is 256 Hz (divisor 128).
        wr(1, 8);
        go(0);
        push_sub(e_cyc, 301, 128);
        stop(0, 301);

        // R4 invalid rate 15: silent; sub-week fed by it does not move.
        wr(1, 15); wr(2, 1); wr(5, 4);
        go(0);
        stop(0, 41);
        check("R4 rate 15 no step", longint'(subwk_count), 4);

        // R5 invalid source 7.
        wr(1, 14); wr(2, 7);
        go(0);
        push_sub(e_cyc, 21, 1);
        stop(0, 21);
        check("R5 source 7 no step", longint'(subwk_count), 4);

        // R9 tick low: nothing advances.
        tick_32k = 1'b0;
        wr(2, 1);
        go(0);
        stop(0, 21);
        check("R9 tick low hold", longint'(subwk_count), 4);
        tick_32k = 1'b1;

        // Seconds 7 -> 8: alarm and bit-3 tap on the same edge.
        wr(1, 0);
        wr(3, 7);
        check("R10 seconds load", longint'(sec_count), 7);
        wr(4, 8); wr(5, 1); wr(2, 3); wr(6, 7);
        check("R11 clear before alarm", longint'(status), 0);
        go(6);
        check("R12 wake flags", longint'(wake_flags), 3);
        lt = 32768 - (pcount % 32768);
        q_alm.push_back(e_cyc + lt);
        q_swk.push_back(e_cyc + lt);
        stop(6, lt + 3);
        check("R1 one second", longint'(sec_count), 8);
        check("R5 tap stepped", longint'(subwk_count), 0);
        check("R11 alarm status", longint'(status), 6);

        // R5 source 2: one-second tick; no alarm with mismatched value.
        wr(3, 30); wr(4, 64'hFFFF_FFFF); wr(5, 1); wr(2, 2);
        go(0);
        lt = 32768 - (pcount % 32768);
        q_swk.push_back(e_cyc + lt);
        stop(0, lt + 3);
        check("R1 second step", longint'(sec_count), 31);
        check("R5 1Hz source", longint'(subwk_count), 0);

        // R9 run clear: frozen with tick running.
        idle(100);
        drain();
        check("R9 frozen seconds", longint'(sec_count), 31);

        summary();
        $finish;
    end
endmodule